// File: doc/BRIEF.md
# Posted Write Retry Engine

This block sequences delivery of one buffered posted write onto a target bus on behalf of a bus bridge. Software-invisible and purely master-side, it takes the start address, command code and DWORD count of the buffered write. It then issues bus attempts, each described by an address, a command and a remaining length, and reacts to how the target ends each attempt.

A retried attempt is reissued unchanged. A disconnect after partial delivery moves the next attempt to the first undelivered DWORD. A write that began as memory-write-and-invalidate falls back to plain memory write once part of its line has gone out. A run of consecutive attempts that deliver nothing is bounded by a parameterised limit. On reaching that limit the engine abandons the write and, unless masked, requests a system-error report.

Top module: `pw_retry_engine`

## Requirements
- R1: Out of reset busy_o, att_req_o, done_o and serr_req_o are all 0.
- R2: start_i while idle makes att_req_o high for exactly one cycle on the next cycle, with att_addr_o = start_addr_i, att_cmd_o = cmd_i and att_len_o = dw_count_i. The engine then waits for a result on res_valid_i.
- R3: A result of kind retry (res_kind_i = 2'b01, and 2'b11 is treated the same) or a disconnect with res_dw_i = 0 that does not end the write is followed, one cycle later, by a new attempt with unchanged address, length and command.
- R4: A disconnect (res_kind_i = 2'b10) with 0 < res_dw_i < att_len_o is followed, one cycle later, by a new attempt at att_addr_o + 4*res_dw_i with length att_len_o - res_dw_i.
- R5: If the attempt command is memory-write-and-invalidate (4'b1111) and a disconnect delivered some but not all DWORDs, later attempts use memory write (4'b0111). Attempts that deliver nothing keep 4'b1111.
- R6: A normal result (res_kind_i = 2'b00), or a disconnect with res_dw_i >= att_len_o, raises done_o for exactly one cycle on the next cycle and returns the engine to idle with no further attempt.
- R7: Only consecutive attempts that deliver zero DWORDs count toward the limit. Any attempt that delivers at least one DWORD restarts the count.
- R8: When RETRY_LIMIT consecutive attempts deliver nothing, busy_o falls on the next cycle, no further attempt is issued and done_o stays 0.
- R9: On abandoning a write, serr_req_o pulses for one cycle if and only if serr_en_i = 1 and nondeliv_dis_i = 0.
- R10: start_i is ignored while busy_o is 1. The write in progress keeps its address, length and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin draining the buffered write (idle only) |
| start_addr_i | input | ADDR_W | Byte address of first DWORD |
| cmd_i | input | 4 | Bus write command |
| dw_count_i | input | CNT_W | Number of buffered DWORDs |
| serr_en_i | input | 1 | System-error reporting enable |
| nondeliv_dis_i | input | 1 | Masks the non-delivery error report |
| res_valid_i | input | 1 | Attempt result valid |
| res_kind_i | input | 2 | 00 normal, 01 retry, 10 disconnect, 11 as retry |
| res_dw_i | input | CNT_W | DWORDs accepted on a disconnect |
| att_req_o | output | 1 | One-cycle request to start a bus attempt |
| att_addr_o | output | ADDR_W | Attempt start address |
| att_cmd_o | output | 4 | Attempt command |
| att_len_o | output | CNT_W | DWORDs still to deliver |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle pulse: all data delivered |
| serr_req_o | output | 1 | One-cycle system-error request on abandon |

## Verification
Random writes mix retries, zero-length, partial and over-long disconnects, and normal ends under both command codes. Each attempt's address, length and command are compared with a model that tells reissue apart from advance and downgrade. A directed all-retry write is run under every combination of the enable and mask bits, which separates the give-up timing from the error gating. A scripted write places single-DWORD deliveries just before the limit, which shows that the count restarts and is not cumulative. A start pulse injected mid-write checks that the running write is left untouched.

// File: rtl/pw_retry_pkg.sv
package pw_retry_pkg;
  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

  typedef enum logic [1:0] {
    RES_NORMAL = 2'b00,
    RES_RETRY  = 2'b01,
    RES_DISC   = 2'b10,
    RES_RSVD   = 2'b11
  } res_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/pw_addr_tracker.sv
module pw_addr_tracker
  import pw_retry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        cmd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              upd_i,
  input  logic [1:0]        kind_i,
  input  logic [CNT_W-1:0]  dw_i,
  output logic              got_any_o,
  output logic              finish_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        cmd_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_disc;
  logic [CNT_W-1:0]  deliv;

  assign is_disc   = (res_kind_e'(kind_i) == RES_DISC);
  // capped at remaining length
  assign deliv     = (dw_i >= cnt_q) ? cnt_q : dw_i;
  assign finish_o  = (res_kind_e'(kind_i) == RES_NORMAL) || (is_disc && dw_i >= cnt_q);
  assign got_any_o = finish_o ? (cnt_q != '0) : (is_disc && deliv != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cmd_q  <= cmd_i;
      cnt_q  <= cnt_i;
    end else if (upd_i && !finish_o && got_any_o) begin
      addr_q <= addr_q + (ADDR_W'(deliv) << 2);
      cnt_q  <= cnt_q - deliv;
      if (cmd_q == CMD_MEM_WR_INV) cmd_q <= CMD_MEM_WR;
    end
  end

  assign addr_o = addr_q;
  assign cmd_o  = cmd_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pw_fail_counter.sv
module pw_fail_counter #(
  parameter int LIMIT = 1 << 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fail_i,
  output logic limit_hit_o
);
  localparam int FAIL_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [FAIL_W-1:0] cnt_q;

  assign limit_hit_o = fail_i && (cnt_q == FAIL_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || limit_hit_o) cnt_q <= '0;
    else if (fail_i)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pw_seq_ctrl.sv
module pw_seq_ctrl
  import pw_retry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic res_valid_i,
  input  logic finish_i,
  input  logic got_any_i,
  input  logic limit_hit_i,
  input  logic serr_en_i,
  input  logic nondeliv_dis_i,
  output logic load_o,
  output logic upd_o,
  output logic fail_o,
  output logic clr_o,
  output logic att_req_o,
  output logic busy_o,
  output logic done_o,
  output logic serr_req_o
);
  seq_state_e state_q, state_d;
  logic done_q, serr_q;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign upd_o     = (state_q == ST_WAIT) && res_valid_i;
  assign fail_o    = upd_o && !finish_i && !got_any_i;
  assign clr_o     = load_o || (upd_o && got_any_i);
  assign att_req_o = (state_q == ST_ISSUE);
  assign busy_o    = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:
        if (res_valid_i) begin
          if (finish_i || limit_hit_i) state_d = ST_IDLE;
          else                         state_d = ST_ISSUE;
        end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= upd_o && finish_i;
      serr_q  <= upd_o && !finish_i && limit_hit_i && serr_en_i && !nondeliv_dis_i;
    end
  end

  assign done_o     = done_q;
  assign serr_req_o = serr_q;
endmodule

// File: rtl/pw_retry_engine.sv
module pw_retry_engine
  import pw_retry_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 10,
  parameter int RETRY_LIMIT = 1 << 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [3:0]        cmd_i,
  input  logic [CNT_W-1:0]  dw_count_i,
  input  logic              serr_en_i,
  input  logic              nondeliv_dis_i,
  input  logic              res_valid_i,
  input  logic [1:0]        res_kind_i,
  input  logic [CNT_W-1:0]  res_dw_i,
  output logic              att_req_o,
  output logic [ADDR_W-1:0] att_addr_o,
  output logic [3:0]        att_cmd_o,
  output logic [CNT_W-1:0]  att_len_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              serr_req_o
);
  logic load, upd, fail, clr, finish, got_any, limit_hit;

  pw_addr_tracker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .addr_i    (start_addr_i),
    .cmd_i     (cmd_i),
    .cnt_i     (dw_count_i),
    .upd_i     (upd),
    .kind_i    (res_kind_i),
    .dw_i      (res_dw_i),
    .got_any_o (got_any),
    .finish_o  (finish),
    .addr_o    (att_addr_o),
    .cmd_o     (att_cmd_o),
    .cnt_o     (att_len_o)
  );

  pw_fail_counter #(.LIMIT(RETRY_LIMIT)) u_fail (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .fail_i      (fail),
    .limit_hit_o (limit_hit)
  );

  pw_seq_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .res_valid_i    (res_valid_i),
    .finish_i       (finish),
    .got_any_i      (got_any),
    .limit_hit_i    (limit_hit),
    .serr_en_i      (serr_en_i),
    .nondeliv_dis_i (nondeliv_dis_i),
    .load_o         (load),
    .upd_o          (upd),
    .fail_o         (fail),
    .clr_o          (clr),
    .att_req_o      (att_req_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .serr_req_o     (serr_req_o)
  );
endmodule

// File: rtl/pw_retry_engine_chk.sv
module pw_retry_engine_chk #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 10,
  parameter int RETRY_LIMIT = 1 << 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [3:0]        cmd_i,
  input logic [CNT_W-1:0]  dw_count_i,
  input logic              serr_en_i,
  input logic              nondeliv_dis_i,
  input logic              res_valid_i,
  input logic [1:0]        res_kind_i,
  input logic [CNT_W-1:0]  res_dw_i,
  input logic              att_req_o,
  input logic [ADDR_W-1:0] att_addr_o,
  input logic [3:0]        att_cmd_o,
  input logic [CNT_W-1:0]  att_len_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              serr_req_o
);
  localparam int CW = $clog2(RETRY_LIMIT + 1) + 1;

  logic res_ok, nodeliv, partial, full;
  logic [CW-1:0] fails_q;

  assign res_ok  = busy_o && !att_req_o && res_valid_i;
  assign full    = (res_kind_i == 2'b00) || (res_kind_i == 2'b10 && res_dw_i >= att_len_o);
  assign partial = (res_kind_i == 2'b10) && res_dw_i != '0 && res_dw_i < att_len_o;
  assign nodeliv = !full && !partial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fails_q <= '0;
    else if (!busy_o)           fails_q <= '0;
    else if (res_ok && nodeliv) fails_q <= fails_q + 1'b1;
    else if (res_ok)            fails_q <= '0;
  end

  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_req_o |=> !att_req_o);

  assert_retry_same_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok && nodeliv) |=> (att_addr_o == $past(att_addr_o)) && (att_len_o == $past(att_len_o)));

  assert_disc_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok && partial) |=>
      (att_addr_o == $past(att_addr_o) + (ADDR_W'($past(res_dw_i)) << 2)) && att_req_o);

  assert_mwi_downgrade_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok && partial) |=> att_cmd_o != 4'b1111);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok && full) |=> done_o && !busy_o && !serr_req_o);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fails_q <= CW'(RETRY_LIMIT));

  assert_give_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_ok && nodeliv && fails_q == CW'(RETRY_LIMIT - 1)) |=> !busy_o && !done_o);

  assert_serr_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_req_o |-> $past(serr_en_i) && !$past(nondeliv_dis_i) && !done_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !res_valid_i) |=> $stable(att_addr_o) && $stable(att_cmd_o) && $stable(att_len_o));
endmodule

bind pw_retry_engine pw_retry_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RETRY_LIMIT(RETRY_LIMIT)
) u_chk (.*);

// File: tb/sim_pw_retry_engine.sv
`timescale 1ns/1ps
module sim_pw_retry_engine;
  localparam int AW = 32;
  localparam int CW = 10;
  localparam int RL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, serr_en = 1'b0, ndis = 1'b0, rv = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [3:0] cmd = '0;
  logic [CW-1:0] cnt = '0, rdw = '0;
  logic [1:0] rkind = '0;
  logic att_req, busy, done, serr;
  logic [AW-1:0] aaddr;
  logic [3:0] acmd;
  logic [CW-1:0] alen;

  int checks = 0, errors = 0;
  int mode = 0;
  bit poke = 1'b0;

  always #5 clk = ~clk;

  pw_retry_engine #(.ADDR_W(AW), .CNT_W(CW), .RETRY_LIMIT(RL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .cmd_i(cmd), .dw_count_i(cnt), .serr_en_i(serr_en), .nondeliv_dis_i(ndis),
    .res_valid_i(rv), .res_kind_i(rkind), .res_dw_i(rdw),
    .att_req_o(att_req), .att_addr_o(aaddr), .att_cmd_o(acmd), .att_len_o(alen),
    .busy_o(busy), .done_o(done), .serr_req_o(serr));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] next_cmd(input logic [3:0] c);
    return (c == 4'b1111) ? 4'b0111 : c;
  endfunction

  task automatic run_txn(input logic [AW-1:0] a, input logic [CW-1:0] n,
                         input logic [3:0] c, input bit en, input bit dis);
    logic [AW-1:0] ea = a;
    logic [CW-1:0] el = n;
    logic [3:0] ec = c;
    int fails = 0;
    int idx = 0;
    string tag = "R2";
    @(negedge clk);
    saddr = a; cnt = n; cmd = c; serr_en = en; ndis = dis; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      bit fin, give;
      logic [1:0] k;
      logic [CW-1:0] d;
      chk(att_req == 1'b1, tag, "att_req", 32'(att_req), 1);
      chk(aaddr == ea, tag, "addr", aaddr, ea);
      chk(alen == el, tag, "len", 32'(alen), 32'(el));
      chk(acmd == ec, (tag == "R4") ? "R5" : tag, "cmd", 32'(acmd), 32'(ec));
      @(negedge clk);
      chk(att_req == 1'b0 && busy, "R2", "single pulse", 32'(att_req), 0);
      if (mode == 1) begin k = 2'b01; d = '0; end
      else if (mode == 2) begin
        if (idx >= 15)         begin k = 2'b00; d = '0; end
        else if (idx % 8 == 7) begin k = 2'b10; d = 1;  end
        else                   begin k = (idx % 2) ? 2'b11 : 2'b01; d = '0; end
      end else begin
        int r = $urandom_range(0, 9);
        if (r < 2)      begin k = 2'b00; d = '0; end
        else if (r < 5) begin k = 2'b01; d = CW'($urandom); end
        else begin k = 2'b10; d = CW'($urandom_range(0, el + 2)); end
      end
      fin  = (k == 2'b00) || (k == 2'b10 && d >= el);
      give = 1'b0;
      if (fin) ;
      else if (k == 2'b10 && d != 0) begin
        ea = ea + 32'(d) * 4; el = el - d; ec = next_cmd(ec); fails = 0; tag = "R4";
      end else begin
        fails++; tag = poke ? "R10" : "R3";
        if (fails == RL) give = 1'b1;
      end
      if (mode == 2 && !fin) tag = "R7";
      rv = 1'b1; rkind = k; rdw = d;
      if (poke) begin start = 1'b1; saddr = ~a; cnt = n + 3; cmd = ~c; end
      @(negedge clk);
      rv = 1'b0; start = 1'b0;
      idx++;
      if (fin) begin
        chk(done && !busy && !serr, (mode == 2) ? "R7" : "R6", "done", {busy, done, serr}, 3'b010);
        @(negedge clk);
        chk(!done && !att_req, "R6", "done pulse", {done, att_req}, 0);
        return;
      end
      if (give) begin
        chk(!busy && !done && !att_req, "R8", "give up", {busy, done, att_req}, 0);
        chk(serr == (en && !dis), "R9", "serr", 32'(serr), 32'(en && !dis));
        @(negedge clk);
        chk(!serr && !busy, "R9", "serr pulse", {serr, busy}, 0);
        return;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    chk(!busy && !att_req && !done && !serr, "R1", "reset", {busy, att_req, done, serr}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && !att_req && !done && !serr, "R1", "after reset", {busy, att_req, done, serr}, 0);

    mode = 1;
    for (int i = 0; i < 4; i++) run_txn(32'h1000 + 32'(i) * 32'h40, 8, 4'b1111, i[0], i[1]);
    mode = 2;
    run_txn(32'h2000, 4, 4'b1111, 1'b1, 1'b0);
    mode = 0; poke = 1'b1;
    run_txn(32'h3000, 6, 4'b0111, 1'b1, 1'b0);
    poke = 1'b0;
    for (int i = 0; i < 60; i++)
      run_txn({$urandom_range(0, 32'hffff), 2'b00}, CW'($urandom_range(1, 24)),
              ($urandom_range(0, 1) != 0) ? 4'b1111 : 4'b0111,
              1'($urandom), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule